// File: doc/BRIEF.md
# Push-Button Byte Stepper for a Narrow LED Display

This block shows a 32-bit result word on a board that has only eight LEDs. The word is split into four 8-bit lanes. Each accepted push-button press puts the next lane on the LED bus, starting with the least significant lane. A 2-bit index output tells the operator which lane is on show. After the fourth lane, the next press starts over at lane zero. That press also takes a fresh snapshot of the input word, so all four lanes of one pass come from one consistent value.

The button level first passes through a two-flop synchronizer, and a press is its rising edge. A three-state sequencer handles each press: idle, transfer, then lockout.

- **Idle** waits for a press.
- **Transfer** puts one lane on the LEDs.
- **Lockout** waits `LOCK_CYCLES` clocks. The default is 25,000,000, which is half a second at 50 MHz. During this time the sequencer ignores the button, so one click can never count as two steps.

Nothing here is a data stream. Every pin is a plain level: the word input is sampled without a handshake, and the outputs hold until the next step. Back-pressure therefore has no meaning for this block.

Top module: `led_byte_stepper`

## Requirements
- R1: While `rst` is high at a clock edge, the block enters idle with `led_out` = 0, `lane_idx` = 0, and the lockout counter cleared. It stays that way until a press.
- R2: The first accepted press after reset shows `word_in[7:0]` on `led_out` with `lane_idx` = 0.
- R3: The following presses show lanes 1, 2 and 3 in that order. Lane k is bits 8k+7 down to 8k of the captured word, and `lane_idx` = k.
- R4: The press after lane 3 wraps to lane 0 with `lane_idx` = 0.
- R5: The word is captured only on a lane-0 transfer. A change to `word_in` after that does not affect lanes 1 to 3 of the same pass.
- R6: A press held for longer than the lockout counts as exactly one step.
- R7: A rising edge of the button during the lockout is ignored and is not queued. After the lockout ends, `led_out` and `lane_idx` are unchanged.
- R8: After the lockout has ended, a new press is accepted again.
- R9: `led_out` and `lane_idx` hold steady between transfers, even while `word_in` changes.
- R10: A rising button level sampled at clock edge n shows up on `led_out` and `lane_idx` at edge n+3, not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| btn_level | input | 1 | Raw push-button level, asynchronous to `clk` |
| word_in | input | 32 | Word to display, sampled at each lane-0 transfer |
| led_out | output | 8 | Lane currently shown |
| lane_idx | output | 2 | Index of the lane currently shown |

## Verification
A wrong lane cursor shows up on `lane_idx` and `led_out` at the very next accepted press: a skipped, repeated or non-wrapping lane appears three clocks after the button edge. A sequencer that leaves the lockout early, or never leaves it, shows up within one lockout period. A bounce press then either steps the display or a later real press fails to. A holding register that recaptures at the wrong moment shows up as a wrong lane 1 to 3 once `word_in` has changed in the middle of a pass.

// File: rtl/stepper_pkg.sv
package stepper_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_XFER  = 2'd1,
    ST_DELAY = 2'd2
  } seq_state_t;
endpackage

// File: rtl/btn_edge_sync.sv
module btn_edge_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_raw,
  output logic press
);
  logic [SYNC_N-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[SYNC_N-2:0], btn_raw};
      last_q  <= chain_q[SYNC_N-1];
    end
  end

  assign press = chain_q[SYNC_N-1] & ~last_q;

  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    press |=> !press);
endmodule

// File: rtl/lockout_timer.sv
module lockout_timer #(
  parameter int LOCK_CYCLES = 25_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);
  localparam int CW = (LOCK_CYCLES > 2) ? $clog2(LOCK_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(LOCK_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (run && !done) cnt_q <= cnt_q + 1'b1;
    else                   cnt_q <= '0;
  end

  assign done = run && (cnt_q == LAST);

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);

  // R1
  idle_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> cnt_q == '0);
endmodule

// File: rtl/lane_stepper.sv
module lane_stepper
  import stepper_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int LANE_W = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        press,
  input  logic                        lock_done,
  input  logic [WORD_W-1:0]           word_in,
  output logic                        in_delay,
  output logic [LANE_W-1:0]           led_out,
  output logic [$clog2(WORD_W/LANE_W)-1:0] lane_idx
);
  localparam int LANES = WORD_W / LANE_W;
  localparam int IW    = $clog2(LANES);
  localparam logic [IW-1:0] LAST_LANE = IW'(LANES - 1);

  seq_state_t            state_q;
  logic [WORD_W-1:0]     hold_q;
  logic [IW-1:0]         cursor_q;
  logic [LANE_W-1:0]     led_q;
  logic [IW-1:0]         idx_q;
  logic [LANE_W-1:0]     lanes [LANES];

  // Lane 0 comes straight from the input (it is captured in the same
  // cycle); the other lanes come from the holding register.
  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      if (g == 0) begin : g_first
        assign lanes[g] = word_in[LANE_W-1:0];
      end else begin : g_rest
        assign lanes[g] = hold_q[g*LANE_W +: LANE_W];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      hold_q   <= '0;
      cursor_q <= '0;
      led_q    <= '0;
      idx_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (press) state_q <= ST_XFER;
        ST_XFER: begin
          if (cursor_q == '0) hold_q <= word_in;
          led_q    <= lanes[cursor_q];
          idx_q    <= cursor_q;
          cursor_q <= (cursor_q == LAST_LANE) ? '0 : cursor_q + 1'b1;
          state_q  <= ST_DELAY;
        end
        ST_DELAY: if (lock_done) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign in_delay = (state_q == ST_DELAY);
  assign led_out  = led_q;
  assign lane_idx = idx_q;

  // R9
  led_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_XFER) |=> ($stable(led_q) && $stable(idx_q)));

  // R3
  cursor_step_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_XFER) |=> (idx_q == $past(cursor_q)));

  // R7
  delay_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DELAY && !lock_done) |=> state_q == ST_DELAY);

  // R6
  xfer_once_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_XFER) |=> state_q == ST_DELAY);

  // R5
  hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_XFER || cursor_q != '0) |=> $stable(hold_q));
endmodule

// File: rtl/led_byte_stepper.sv
module led_byte_stepper #(
  parameter int WORD_W      = 32,
  parameter int LANE_W      = 8,
  parameter int LOCK_CYCLES = 25_000_000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        btn_level,
  input  logic [31:0] word_in,
  output logic [7:0]  led_out,
  output logic [1:0]  lane_idx
);
  logic press;
  logic in_delay;
  logic lock_done;

  btn_edge_sync #(.SYNC_N(2)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .btn_raw (btn_level),
    .press   (press)
  );

  lockout_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .run  (in_delay),
    .done (lock_done)
  );

  lane_stepper #(.WORD_W(WORD_W), .LANE_W(LANE_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .press     (press),
    .lock_done (lock_done),
    .word_in   (word_in),
    .in_delay  (in_delay),
    .led_out   (led_out),
    .lane_idx  (lane_idx)
  );
endmodule

// File: tb/led_byte_stepper_test.sv
module led_byte_stepper_test;
  localparam int LOCK = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        btn_level = 1'b0;
  logic [31:0] word_in = '0;
  logic [7:0]  led_out;
  logic [1:0]  lane_idx;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  led_byte_stepper #(.LOCK_CYCLES(LOCK)) uut (
    .clk(clk), .rst(rst), .btn_level(btn_level),
    .word_in(word_in), .led_out(led_out), .lane_idx(lane_idx)
  );

  always #5ns clk = ~clk;

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_press(input int hold);
    @(negedge clk) btn_level = 1'b1;
    repeat (hold) @(negedge clk);
    btn_level = 1'b0;
    repeat (LOCK + 6) @(negedge clk);
  endtask

  initial begin
    #1ms;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] snap;
    logic [1:0]  cur;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    word_in = 32'hA1B2C3D4;
    repeat (3) @(negedge clk);
    check("R1 led", {2'b0, led_out}, 10'h0);
    check("R1 idx", {8'b0, lane_idx}, 10'h0);

    // R10: latency of the first press, which is also R2
    @(negedge clk) btn_level = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 early", {lane_idx, led_out}, 10'h0);
    @(negedge clk);
    check("R10 on time", {lane_idx, led_out}, {2'd0, 8'hD4});
    btn_level = 1'b0;
    repeat (LOCK + 6) @(negedge clk);
    check("R2 first lane", {lane_idx, led_out}, {2'd0, 8'hD4});
    snap = 32'hA1B2C3D4;
    cur  = 2'd1;

    // R5: the word changes in the middle of a pass
    word_in = 32'h5E6F7081;

    // Sweep several words through full passes, including wraps
    for (int w = 0; w < 6; w++) begin
      for (int s = 0; s < 4; s++) begin
        int hold;
        hold = (w == 1 && s == 2) ? LOCK + 5 : 2;
        if (cur == 2'd0) snap = word_in;
        do_press(hold);
        if (cur == 2'd0)
          check("R4 wrap lane 0", {lane_idx, led_out}, {2'd0, snap[7:0]});
        else if (hold > 2)
          check("R6 long press one step", {lane_idx, led_out}, {cur, snap[cur*8 +: 8]});
        else
          check("R3/R5 next lane", {lane_idx, led_out}, {cur, snap[cur*8 +: 8]});
        cur = cur + 2'd1;
        word_in = word_in * 32'd2654435761 + 32'd12345;
      end
    end

    // R7: a bounce press inside the lockout is dropped; R8: a later press counts
    if (cur == 2'd0) snap = word_in;
    @(negedge clk) btn_level = 1'b1;
    repeat (2) @(negedge clk) btn_level = 1'b0;
    repeat (3) @(negedge clk);
    btn_level = 1'b1;
    repeat (2) @(negedge clk);
    btn_level = 1'b0;
    repeat (LOCK + 8) @(negedge clk);
    check("R7 bounce ignored", {lane_idx, led_out}, {cur, snap[cur*8 +: 8]});
    cur = cur + 2'd1;
    if (cur == 2'd0) snap = word_in;
    do_press(2);
    check("R8 press after lockout", {lane_idx, led_out}, {cur, snap[cur*8 +: 8]});

    // R9: outputs hold while the word changes and nothing is pressed
    for (int k = 0; k < 5; k++) begin
      word_in = ~word_in + 32'(k);
      repeat (3) @(negedge clk);
      check("R9 steady", {lane_idx, led_out}, {cur, snap[cur*8 +: 8]});
    end

    // R1: reset again from a non-zero lane
    rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    check("R1 reset again", {lane_idx, led_out}, 10'h0);
    word_in = 32'h00000077;
    do_press(2);
    check("R2 after reset", {lane_idx, led_out}, {2'd0, 8'h77});

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule